// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Decoder

This block is the digital front end of a two-channel 12-bit converter. A host sends 16-bit command words over a three-wire serial link: an active-low select, a serial clock and a data line. The block brings those three lines into a faster system clock domain and assembles each word. It then decodes the word and updates the output code registers and mode flags that drive the analog core.

Each word carries a two-bit target select, a settling-speed flag, a power-down flag and a 12-bit payload. The payload can go to channel A, to channel B, or to a staging register, or it can program the reference choice. One select value writes channel A and, in the same commit, moves the staged value into channel B, so both analog outputs step together. A word is committed after sixteen bits have arrived, or earlier if the select line is released after at least one bit.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset, both channel codes, the staging register, the reference select, the fast flag, the power-down flag and the commit strobe are all zero.
- R2: Bits are sampled on falling serial-clock edges while select is low, most significant bit first. After the sixteenth bit the word is committed once, and `commit_stb` is high for exactly one system cycle, in the same cycle the outputs take their new values.
- R3: Select code 00 (word bit 15 = 0, bit 12 = 0) writes the payload (bits 11..0) to both channel B and the staging register.
- R4: Select code 01 (bit 15 = 0, bit 12 = 1) writes the payload to the staging register only. Both channel outputs keep their values.
- R5: Select code 10 (bit 15 = 1, bit 12 = 0) writes the payload to channel A and copies the staging register into channel B on the same system clock edge.
- R6: Select code 11 (bit 15 = 1, bit 12 = 1) sets `ref_sel` to payload bits 1..0. Here 01 selects internal 1.024 V, 10 selects internal 2.048 V, and 00 or 11 selects external. Payload bits 11..2 are ignored, and both channel codes are unchanged.
- R7: Every committed word loads `fast_mode` from bit 14 and `power_down` from bit 13, whatever the select code. A set bit 13 forces power-down.
- R8: If select rises after n bits, with 1 ≤ n < 16, the received bits are committed right-aligned in bits n-1..0, and the upper bits are zero.
- R9: If select rises before any bit has been sampled, nothing is committed and no output changes.
- R10: Serial-clock edges after the sixteenth bit of a frame are ignored. The frame produces exactly one commit, holding the first sixteen bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock, data sampled on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| dac_a_code | output | 12 | Channel A output code |
| dac_b_code | output | 12 | Channel B output code |
| fast_mode | output | 1 | 1 = fast settling, 0 = slow |
| power_down | output | 1 | 1 = powered down, 0 = normal |
| ref_sel | output | 2 | Reference choice from the last control write |
| commit_stb | output | 1 | One-cycle pulse when a word is applied |

## Verification
The assertions assume the serial lines are far slower than the system clock. Each serial-clock level and each select level must last several system cycles. The data line must be stable around every falling serial-clock edge, so that one synchronised edge yields exactly one sample and commits are many cycles apart. The stimulus holds every serial-clock phase for four system cycles and sets data while the serial clock is high. It leaves gaps of several cycles around every select transition, and it never moves select and serial clock in the same cycle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int WORD_W  = 16;
    localparam int DATA_W  = 12;
    localparam int REF_W   = 2;
    // word field positions (decoded by the register stage)
    localparam int POS_SEL_HI = 15;
    localparam int POS_FAST   = 14;
    localparam int POS_PDN    = 13;
    localparam int POS_SEL_LO = 12;

    typedef enum logic [1:0] {
        TGT_B_AND_STAGE = 2'b00,
        TGT_STAGE_ONLY  = 2'b01,
        TGT_A_WITH_XFER = 2'b10,
        TGT_CONTROL     = 2'b11
    } target_e;

    typedef logic [DATA_W-1:0] code_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/dsc_shifter.sv
module dsc_shifter
    import dsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_s,
    input  logic  sck_s,
    input  logic  din_s,
    output logic  word_vld,
    output word_t word
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        word_t            sh;
        logic             cs_p;
        logic             sck_p;
        logic             vld;
        word_t            word;
    } sh_st_t;

    sh_st_t st_d, st_q;
    word_t  nsh;
    logic   cs_fall, cs_rise, sck_fall;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.cs_p  = cs_s;
        st_d.sck_p = sck_s;
        cs_fall  = st_q.cs_p & ~cs_s;
        cs_rise  = ~st_q.cs_p & cs_s;
        sck_fall = st_q.sck_p & ~sck_s;
        nsh      = {st_q.sh[WORD_W-2:0], din_s};
        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.sh     = '0;
        end else if (cs_rise) begin
            if (st_q.active && st_q.cnt != '0) begin
                st_d.vld  = 1'b1;
                st_d.word = st_q.sh;
            end
            st_d.active = 1'b0;
        end else if (sck_fall && st_q.active && !cs_s) begin
            st_d.sh  = nsh;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                st_d.vld    = 1'b1;
                st_d.word   = nsh;
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, cnt: '0, sh: '0, cs_p: 1'b1,
                              sck_p: 1'b0, vld: 1'b0, word: '0};
        else        st_q <= st_d;
    end

    assign word_vld = st_q.vld;
    assign word     = st_q.word;
endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
    import dsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [DATA_W-1:0] dac_a_code,
    output logic [DATA_W-1:0] dac_b_code,
    output logic              fast_mode,
    output logic              power_down,
    output logic [REF_W-1:0]  ref_sel,
    output logic              commit_stb
);
    typedef struct packed {
        code_t            a;
        code_t            b;
        code_t            stage;
        logic [REF_W-1:0] refs;
        logic             fast;
        logic             pdn;
        logic             stb;
    } regs_t;

    logic [2:0] pins_s;
    logic       cmt_vld;
    word_t      cmt_word;
    code_t      stage_code;
    target_e    tgt;
    regs_t      r_d, r_q;

    dsc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk, sdin}),
        .dout (pins_s)
    );

    dsc_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (pins_s[2]),
        .sck_s   (pins_s[1]),
        .din_s   (pins_s[0]),
        .word_vld(cmt_vld),
        .word    (cmt_word)
    );

    assign tgt = target_e'({cmt_word[POS_SEL_HI], cmt_word[POS_SEL_LO]});

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;
        if (cmt_vld) begin
            r_d.stb  = 1'b1;
            r_d.fast = cmt_word[POS_FAST];
            r_d.pdn  = cmt_word[POS_PDN];
            unique case (tgt)
                TGT_B_AND_STAGE: begin
                    r_d.b     = cmt_word[DATA_W-1:0];
                    r_d.stage = cmt_word[DATA_W-1:0];
                end
                TGT_STAGE_ONLY:  r_d.stage = cmt_word[DATA_W-1:0];
                TGT_A_WITH_XFER: begin
                    r_d.a = cmt_word[DATA_W-1:0];
                    r_d.b = r_q.stage;
                end
                TGT_CONTROL:     r_d.refs = cmt_word[REF_W-1:0];
                default:         r_d.refs = r_q.refs;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stage_code = r_q.stage;
    assign dac_a_code = r_q.a;
    assign dac_b_code = r_q.b;
    assign fast_mode  = r_q.fast;
    assign power_down = r_q.pdn;
    assign ref_sel    = r_q.refs;
    assign commit_stb = r_q.stb;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
    import dsc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmt_vld,
    input word_t             cmt_word,
    input code_t             stage_code,
    input logic [DATA_W-1:0] dac_a_code,
    input logic [DATA_W-1:0] dac_b_code,
    input logic              fast_mode,
    input logic              power_down,
    input logic [REF_W-1:0]  ref_sel,
    input logic              commit_stb
);
    logic [1:0] sel;
    assign sel = {cmt_word[POS_SEL_HI], cmt_word[POS_SEL_LO]};

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (dac_a_code == '0 && dac_b_code == '0 && stage_code == '0 &&
                    ref_sel == '0 && !fast_mode && !power_down && !commit_stb));

    // R2
    a_r2_commit_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_vld |=> commit_stb);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> !commit_stb);

    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |-> ($stable(dac_a_code) && $stable(dac_b_code) &&
                         $stable(ref_sel) && $stable(power_down)));

    a_r3_b_and_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_vld && sel == 2'b00) |=>
        (dac_b_code == $past(cmt_word[DATA_W-1:0]) && stage_code == $past(cmt_word[DATA_W-1:0])));

    a_r4_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_vld && sel == 2'b01) |=>
        ($stable(dac_a_code) && $stable(dac_b_code) && stage_code == $past(cmt_word[DATA_W-1:0])));

    a_r5_joint_update: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_vld && sel == 2'b10) |=>
        (dac_a_code == $past(cmt_word[DATA_W-1:0]) && dac_b_code == $past(stage_code)));

    a_r6_control_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_vld && sel == 2'b11) |=>
        (ref_sel == $past(cmt_word[REF_W-1:0]) && $stable(dac_a_code) && $stable(dac_b_code)));

    a_r7_mode_flags: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_vld |=> (fast_mode == $past(cmt_word[POS_FAST]) && power_down == $past(cmt_word[POS_PDN])));
endmodule

bind dac_serial_ctrl dsc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmt_vld    (cmt_vld),
    .cmt_word   (cmt_word),
    .stage_code (stage_code),
    .dac_a_code (dac_a_code),
    .dac_b_code (dac_b_code),
    .fast_mode  (fast_mode),
    .power_down (power_down),
    .ref_sel    (ref_sel),
    .commit_stb (commit_stb)
);

// File: tb/tb_dac_serial_ctrl.sv
module tb_dac_serial_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic [11:0] dac_a_code, dac_b_code;
    logic        fast_mode, power_down, commit_stb;
    logic [1:0]  ref_sel;

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] a;
        logic [11:0] b;
        logic [1:0]  r;
        logic        f;
        logic        p;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // bench model state
    logic [11:0] m_a = '0, m_b = '0, m_stage = '0;
    logic [1:0]  m_r = '0;
    logic        m_f = 1'b0, m_p = 1'b0;

    always #2 clk = ~clk;

    dac_serial_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .dac_a_code(dac_a_code), .dac_b_code(dac_b_code),
        .fast_mode(fast_mode), .power_down(power_down),
        .ref_sel(ref_sel), .commit_stb(commit_stb)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: updates the model, pushes the expectation, shifts the bits
    task automatic frame(input logic [31:0] bits, input int n, input string tag);
        logic [15:0] w;
        exp_t e;
        if (n > 0) begin
            if (n >= 16) w = 16'(bits >> (n - 16));
            else         w = 16'(bits & ((32'd1 << n) - 1));
            m_f = w[14];
            m_p = w[13];
            case ({w[15], w[12]})
                2'b00: begin m_b = w[11:0]; m_stage = w[11:0]; end
                2'b01: m_stage = w[11:0];
                2'b10: begin m_b = m_stage; m_a = w[11:0]; end
                default: m_r = w[1:0];
            endcase
            e.a = m_a; e.b = m_b; e.r = m_r; e.f = m_f; e.p = m_p; e.tag = tag;
            exp_q.push_back(e);
        end
        @(negedge clk) cs_n = 1'b0;
        repeat (5) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b1;
            sdin = bits[i];
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && commit_stb) begin
            exp_t e;
            strobes++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected commit", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                chk(dac_a_code == e.a, e.tag, "dac_a", dac_a_code, e.a);
                chk(dac_b_code == e.b, e.tag, "dac_b", dac_b_code, e.b);
                chk(ref_sel == e.r, e.tag, "ref_sel", ref_sel, e.r);
                chk(fast_mode == e.f, e.tag, "fast", fast_mode, e.f);
                chk(power_down == e.p, e.tag, "pdn", power_down, e.p);
            end
        end
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(dac_a_code == 0 && dac_b_code == 0, "R1", "codes", {dac_a_code, dac_b_code}, 0);
        chk(ref_sel == 0 && !fast_mode && !power_down && !commit_stb, "R1", "flags",
            {ref_sel, fast_mode, power_down, commit_stb}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        frame(32'hDAB6, 16, "R6");   // control, ref 10, junk high payload, fast
        frame(32'hC5A5, 16, "R5");   // A=5A5, B<=stage(0)
        frame(32'h0123, 16, "R3");   // B and stage = 123
        frame(32'h1FED, 16, "R4");   // stage only = FED
        frame(32'h80F0, 16, "R5");   // A=0F0, B<=FED
        frame(32'h2777, 16, "R7");   // power-down set with channel write
        frame(32'hF001, 16, "R7");   // control with pdn+fast, ref 01
        frame(32'h00C5, 8,  "R8");   // partial 8 bits -> 00C5
        s0 = strobes;
        frame(32'h0, 0, "R9");       // empty frame
        chk(strobes == s0, "R9", "commits after empty frame", strobes, s0);
        chk(dac_a_code == 12'h0F0 && dac_b_code == 12'h0C5, "R9", "codes held",
            {dac_a_code, dac_b_code}, {12'h0F0, 12'h0C5});
        s0 = strobes;
        frame(32'h81234, 20, "R10"); // 20 edges, first 16 = 8123
        chk(strobes == s0 + 1, "R10", "one commit per long frame", strobes, s0 + 1);
        frame(32'h0DFF, 12, "R8");   // partial 12 bits -> 0DFF
        frame(32'hC3FF, 16, "R2");   // A=3FF fast, B<=DFF

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "pending commits", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule